// File: doc/BRIEF.md
# Per-Block Lock Guard for Program and Erase Requests

This block decides, one request at a time, whether a program or erase operation aimed at a storage block may go ahead. It keeps one lock bit for each of 512 blocks, arranged as 16 pages of 32 blocks. A command port sets or clears single lock bits and clears the error flag. A request port carries a page number and a block-in-page number and returns either a grant or a deny pulse to the operation sequencer.

A global `lock_override` input selects the policy. When it is low, a request to a locked block is denied and a sticky error flag is raised. When it is high, every request is granted whatever the lock bits hold. A separate status port reads back the lock bit of any block. The lock bits stand in for non-volatile cells, so reset leaves them unchanged. Reset only clears the answer and error state.

Top module: `blk_lock_guard`

## Requirements
- R1: The block index is page × 32 + block-in-page. A lock command (`cmd_op` 01 = lock, 10 = unlock) changes the bit of that one block only, and no other block's status changes.
- R2: The status output `stat_locked` shows the lock bit of the block addressed by `stat_page`/`stat_blk` on the clock edge after the address is presented. Lock is 1 and unlocked is 0.
- R3: With `lock_override` low, a request to a locked block gives `deny` = 1 and `grant` = 0 in the cycle after the request. This holds for both program and erase requests.
- R4: With `lock_override` low, a request to an unlocked block gives `grant` = 1 and `deny` = 0 in the cycle after the request.
- R5: With `lock_override` high, every request gives `grant` = 1 in the cycle after the request, even when the block is locked.
- R6: `grant` and `deny` are never high together. A cycle with no request yields neither of them in the following cycle.
- R7: A deny sets `err_flag`. The flag stays set until a clear-status command (`cmd_op` 11) is issued, and it is low on the edge after that command.
- R8: If a deny and a clear-status command fall in the same cycle, `err_flag` ends up set.
- R9: A synchronous reset (`rst` high) clears `grant`, `deny` and `err_flag` but keeps all lock bits.
- R10: If a request and a lock command target the same block in the same cycle, the request is judged on the lock bit as it was before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of answer and error state |
| lock_override | input | 1 | High: ignore all lock bits; low: enforce them |
| cmd_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 clear error flag |
| cmd_page | input | 4 | Page of the lock command |
| cmd_blk | input | 5 | Block within page of the lock command |
| req_valid | input | 1 | Operation request present this cycle |
| req_erase | input | 1 | 1 erase, 0 program (same lock rule) |
| req_page | input | 4 | Page of the requested operation |
| req_blk | input | 5 | Block within page of the requested operation |
| stat_page | input | 4 | Page for status readback |
| stat_blk | input | 5 | Block within page for status readback |
| grant | output | 1 | One-cycle pulse: request allowed |
| deny | output | 1 | One-cycle pulse: request refused |
| err_flag | output | 1 | Sticky refusal flag |
| stat_locked | output | 1 | Lock bit of the addressed block |

## Verification
All four results are registered once and are due on the first rising edge after the inputs that cause them: `grant` and `deny` from the request, `err_flag` from a deny or a clear command, and `stat_locked` from the status address. The bench changes its inputs on the falling edge and samples one time unit after the next rising edge. Before it applies a command, it computes each expected value from its own lock model. This makes the check for a same-cycle request and lock command see the old bit, as R10 requires.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_LOCK    = 2'b01,
    OP_UNLOCK  = 2'b10,
    OP_CLR_ERR = 2'b11
  } lock_op_e;

endpackage

// File: rtl/lock_store.sv
module lock_store #(
  parameter int NBLK  = 512,
  parameter int IDX_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] chk_idx,
  output logic             chk_locked,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_locked
);

  // lock cells model non-volatile storage: no reset, power-up value zero
  logic [NBLK-1:0] bits_q = '0;

  always_ff @(posedge clk) begin
    if (wr_en) bits_q[wr_idx] <= wr_val;
  end

  // request path reads the pre-write value (write lands at the edge)
  assign chk_locked = bits_q[chk_idx];

  always_ff @(posedge clk) begin
    rd_locked <= bits_q[rd_idx];
  end

endmodule

// File: rtl/access_judge.sv
module access_judge (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic locked,
  input  logic override,
  input  logic clr_err,
  output logic grant_o,
  output logic deny_o,
  output logic err_o
);

  logic refuse;
  assign refuse = req_valid && locked && !override;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      grant_o <= req_valid && !refuse;
      deny_o  <= refuse;
      if (refuse)       err_o <= 1'b1;
      else if (clr_err) err_o <= 1'b0;
    end
  end

  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && deny_o));
  a_r6_answer: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (grant_o || deny_o));
  a_r6_silent: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(grant_o || deny_o));
  a_r5_override: assert property (@(posedge clk) disable iff (rst)
    (req_valid && override) |=> grant_o);
  a_r3_refuse: assert property (@(posedge clk) disable iff (rst)
    (req_valid && locked && !override) |=> deny_o);
  a_r7_set: assert property (@(posedge clk) disable iff (rst)
    deny_o |-> err_o);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_err) |=> err_o);
  a_r8_deny_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_err && refuse) |=> err_o);

endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard #(
  parameter int PAGES         = 16,
  parameter int BLKS_PER_PAGE = 32,
  localparam int NBLK   = PAGES * BLKS_PER_PAGE,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int SUB_W  = $clog2(BLKS_PER_PAGE),
  localparam int IDX_W  = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_override,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [SUB_W-1:0]  cmd_blk,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [SUB_W-1:0]  req_blk,
  input  logic [PAGE_W-1:0] stat_page,
  input  logic [SUB_W-1:0]  stat_blk,
  output logic              grant,
  output logic              deny,
  output logic              err_flag,
  output logic              stat_locked
);
  import blk_lock_pkg::*;

  function automatic logic [IDX_W-1:0] flat(input logic [PAGE_W-1:0] p,
                                            input logic [SUB_W-1:0] b);
    return IDX_W'(p) * IDX_W'(BLKS_PER_PAGE) + IDX_W'(b);
  endfunction

  lock_op_e op;
  assign op = lock_op_e'(cmd_op);

  logic wr_en, wr_val, clr_err, locked_now;
  assign wr_en   = (op == OP_LOCK) || (op == OP_UNLOCK);
  assign wr_val  = (op == OP_LOCK);
  assign clr_err = (op == OP_CLR_ERR);

  // program and erase follow the same lock rule
  logic unused_kind;
  assign unused_kind = req_erase;

  lock_store #(.NBLK(NBLK), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .wr_en      (wr_en),
    .wr_idx     (flat(cmd_page, cmd_blk)),
    .wr_val     (wr_val),
    .chk_idx    (flat(req_page, req_blk)),
    .chk_locked (locked_now),
    .rd_idx     (flat(stat_page, stat_blk)),
    .rd_locked  (stat_locked)
  );

  access_judge u_judge (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .locked    (locked_now),
    .override  (lock_override),
    .clr_err   (clr_err),
    .grant_o   (grant),
    .deny_o    (deny),
    .err_o     (err_flag)
  );

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !(grant || deny || err_flag));

endmodule

// File: tb/test_blk_lock_guard.sv
module test_blk_lock_guard;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, ovr = 1'b0, req_valid = 1'b0, req_erase = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [3:0] cmd_page = '0, req_page = '0, stat_page = '0;
  logic [4:0] cmd_blk = '0, req_blk = '0, stat_blk = '0;
  logic       grant, deny, err_flag, stat_locked;

  blk_lock_guard i_blk_lock_guard (
    .clk(clk), .rst(rst), .lock_override(ovr), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .cmd_blk(cmd_blk), .req_valid(req_valid),
    .req_erase(req_erase), .req_page(req_page), .req_blk(req_blk),
    .stat_page(stat_page), .stat_blk(stat_blk), .grant(grant), .deny(deny),
    .err_flag(err_flag), .stat_locked(stat_locked)
  );

  int total = 0, bad = 0;
  bit exp_lock [512];
  bit exp_err = 0;
  bit finished = 0;

  function automatic int fidx(input int p, input int b);
    return p * 32 + b;
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample just after rising edge
  task automatic step(input bit r, input bit o, input int op, input int cp, input int cb,
                      input bit rv, input bit rk, input int rp, input int rb,
                      input int sp, input int sb, input string tag);
    bit e_g, e_d, e_s, lk;
    string rq;
    @(negedge clk);
    rst = r; ovr = o; cmd_op = 2'(op); cmd_page = 4'(cp); cmd_blk = 5'(cb);
    req_valid = rv; req_erase = rk; req_page = 4'(rp); req_blk = 5'(rb);
    stat_page = 4'(sp); stat_blk = 5'(sb);
    lk  = exp_lock[fidx(rp, rb)];
    e_s = exp_lock[fidx(sp, sb)];
    e_d = !r && rv && lk && !o;
    e_g = !r && rv && !e_d;
    if (r) exp_err = 0;
    else if (e_d) exp_err = 1;
    else if (op == 3) exp_err = 0;
    if (op == 1) exp_lock[fidx(cp, cb)] = 1;
    if (op == 2) exp_lock[fidx(cp, cb)] = 0;
    if (r) rq = "R9";
    else if (!rv) rq = "R6";
    else if (o) rq = "R5";
    else if (lk) rq = "R3";
    else rq = "R4";
    @(posedge clk);
    #1;
    chk({tag, " ", rq}, "grant", grant, e_g);
    chk({tag, " ", rq}, "deny", deny, e_d);
    chk({tag, " R7"}, "err_flag", err_flag, exp_err);
    chk({tag, " R2"}, "stat_locked", stat_locked, e_s);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    // reset state
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, 5, 9, 5, 9, "R4");
    // R1: lock one block, neighbours stay unlocked
    step(0, 0, 1, 3, 7, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 7, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 6, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 8, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 7, "R1");
    // R3 program and erase denied; R7 sticky
    step(0, 0, 0, 0, 0, 1, 0, 3, 7, 3, 7, "R3");
    step(0, 0, 0, 0, 0, 1, 1, 3, 7, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R5 override grants locked block
    step(0, 1, 0, 0, 0, 1, 1, 3, 7, 0, 0, "R5");
    // R7 clear status
    step(0, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R8: deny with clear in same cycle
    step(0, 0, 3, 0, 0, 1, 0, 3, 7, 0, 0, "R8");
    chk("R8", "err_flag", err_flag, 1);
    // R10: unlock and request same block same cycle -> old (locked) value
    step(0, 0, 2, 3, 7, 1, 0, 3, 7, 3, 7, "R10");
    chk("R10", "deny", deny, 1);
    step(0, 0, 0, 0, 0, 1, 0, 3, 7, 3, 7, "R10");
    chk("R10", "grant", grant, 1);
    // R9: reset keeps locks, clears error
    step(0, 0, 1, 15, 31, 1, 0, 15, 31, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, 15, 31, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 1, 0, 15, 31, 15, 31, "R9");
    chk("R9", "stat_locked after reset", stat_locked, 1);
    step(0, 0, 0, 0, 0, 1, 0, 15, 31, 15, 31, "R9");
    chk("R9", "deny after reset", deny, 1);
    // random mix focused on a few blocks
    for (int i = 0; i < 2000; i++) begin
      int cp, cb, rp, rb, sp, sb;
      cp = $urandom % 3; cb = $urandom % 4;
      rp = $urandom % 3; rb = $urandom % 4;
      sp = $urandom % 3; sb = $urandom % 4;
      if ($urandom % 8 == 0) begin rp = $urandom % 16; rb = $urandom % 32; end
      step(($urandom % 50) == 0, ($urandom % 4) == 0, $urandom % 4, cp, cb,
           $urandom % 2, $urandom % 2, rp, rb, sp, sb, "RND");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule